// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits beside an 8-bit parallel NOR flash array model and decodes the command protocol that the host drives on the flash's asynchronous write pins. It watches the active-low chip enable and write enable, captures each write cycle as an address of at least 15 bits and a data byte, and follows the multi-write unlock sequences that guard byte programming and 4KB sector erasure. When a sequence completes, it issues a one-cycle strobe: either a program strobe with the target address and byte, or an erase strobe with the sector number.

The strobes are asynchronous to the system clock. They are brought in through two-flop synchronisers, and their edges are found by comparing successive samples. The address and data buses are delayed through a matching pipeline, so each captured value belongs to the same sample as the edge it is paired with. A write opens when the later of the two enables falls, and the address is taken at that point. It closes when the first enable rises, and the data is taken there. A write that does not fit the expected step drops the machine back to idle.

An optional busy counter stands in for the program or erase time. While it runs, further writes are dropped.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, and after a reset applied in the middle of a sequence, both strobes and busy are low and the machine is idle, so a following lone data write programs nothing.
- R2: The write series 0xAA at 0x5555, 0x55 at 0x2AAA, 0xA0 at 0x5555, then any byte at any address, produces one prog_stb pulse with prog_addr and prog_data equal to that last write's address and byte.
- R3: The write series 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, then 0x30 at any address, produces one erase_stb pulse with erase_sector equal to address bits [ADDR_W-1:12] of that last write.
- R4: Command addresses are matched on address bits [14:0] only, and higher bits are ignored (0x15555 acts as 0x5555, 0x0AAAA acts as 0x2AAA).
- R5: A write whose address or data differs from the expected step returns the machine to idle without a pulse. A repeated first unlock write also counts as a mismatch.
- R6: A write of 0xF0 returns the machine to idle from every state except the final data step of a program. In that step any byte, 0xF0 included, is programmed.
- R7: The address is captured when a write opens (the later falling enable) and the data when it closes (the first rising enable). Either enable may be the one that controls the write.
- R8: busy rises together with a strobe and stays high for exactly BUSY_CYCLES clock cycles. Writes made while it is high are dropped and leave the sequence position unchanged.
- R9: Each strobe lasts one clock cycle, and the two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flash_ce_n | input | 1 | Active-low chip enable from the host, asynchronous |
| flash_we_n | input | 1 | Active-low write enable from the host, asynchronous |
| flash_addr | input | ADDR_W | Host address bus |
| flash_data | input | 8 | Host write data bus |
| prog_stb | output | 1 | One-cycle program request |
| prog_addr | output | ADDR_W | Address of the byte to program |
| prog_data | output | 8 | Byte to program |
| erase_stb | output | 1 | One-cycle sector erase request |
| erase_sector | output | ADDR_W-12 | Number of the 4KB sector to erase |
| busy | output | 1 | Simulated operation time in progress |

## Verification
The bench builds the block with a 17-bit address, two synchroniser stages, a three-cycle address hold window and a 60-cycle busy time. The 17-bit address puts a bit above bit 14 within reach, which shows that command matching ignores high bits, and it gives a five-bit sector number whose top bit can be checked. The 60-cycle busy window is long enough to fit a full three-write unlock inside it, so a dropped sequence can be told apart from a completed one. The three-cycle hold window lets the host move the address while one enable is already low, without violating the hold rule.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for first key
    ST_UNL1,   // first key seen
    ST_UNL2,   // second key seen
    ST_PROG,   // program opcode seen, next write is the data
    ST_ERA1,   // erase opcode seen
    ST_ERA2,   // erase re-key one
    ST_ERA3    // erase re-key two, next write names the sector
  } seq_state_e;

  localparam int unsigned CMD_AW = 15;

  localparam logic [CMD_AW-1:0] CMD_ADDR_A = 15'h5555;
  localparam logic [CMD_AW-1:0] CMD_ADDR_B = 15'h2AAA;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;
  localparam logic [7:0] OP_PROGRAM = 8'hA0;
  localparam logic [7:0] OP_ERASE   = 8'h80;
  localparam logic [7:0] OP_SECTOR  = 8'h30;
  localparam logic [7:0] OP_RESET   = 8'hF0;

endpackage

// File: rtl/flash_bus_sync.sv
module flash_bus_sync #(
  parameter int unsigned ADDR_W      = 17,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD_CLKS   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);

  localparam int unsigned LAST   = SYNC_STAGES - 1;
  localparam int unsigned HOLD_W = (HOLD_CLKS < 1) ? 1 : $clog2(HOLD_CLKS + 1);

  // Enable synchronisers and matching bus delay lines
  logic [SYNC_STAGES-1:0] ce_sh, we_sh;
  logic [ADDR_W-1:0]      a_sh [SYNC_STAGES];
  logic [7:0]             d_sh [SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_sh <= '1;
      we_sh <= '1;
      for (int i = 0; i < SYNC_STAGES; i++) begin
        a_sh[i] <= '0;
        d_sh[i] <= '0;
      end
    end else begin
      ce_sh[0] <= ce_n;
      we_sh[0] <= we_n;
      a_sh[0]  <= addr;
      d_sh[0]  <= data;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        ce_sh[i] <= ce_sh[i-1];
        we_sh[i] <= we_sh[i-1];
        a_sh[i]  <= a_sh[i-1];
        d_sh[i]  <= d_sh[i-1];
      end
    end
  end

  // Write window: both enables low in the same sample
  logic act_now, act_q;
  logic open_evt, close_evt;

  assign act_now   = ~ce_sh[LAST] & ~we_sh[LAST];
  assign open_evt  =  act_now & ~act_q;
  assign close_evt = ~act_now &  act_q;

  logic [ADDR_W-1:0] addr_lat, addr_lat_d;
  logic [7:0]        data_lat_d;
  logic [HOLD_W-1:0] hold_cnt, hold_cnt_d;

  always_comb begin
    addr_lat_d = addr_lat;
    data_lat_d = wr_data;
    hold_cnt_d = hold_cnt;
    if (open_evt) begin
      addr_lat_d = a_sh[LAST];
      hold_cnt_d = HOLD_W'(HOLD_CLKS);
    end else if (hold_cnt != '0) begin
      hold_cnt_d = hold_cnt - 1'b1;
    end
    if (close_evt) begin
      data_lat_d = d_sh[LAST];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= 1'b0;
      addr_lat <= '0;
      hold_cnt <= '0;
      wr_valid <= 1'b0;
      wr_data  <= '0;
    end else begin
      act_q    <= act_now;
      addr_lat <= addr_lat_d;
      hold_cnt <= hold_cnt_d;
      wr_valid <= close_evt;
      wr_data  <= data_lat_d;
    end
  end

  assign wr_addr = addr_lat;

  // R7: the address stays put for the hold window after it is captured
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_cnt != '0) |-> (a_sh[LAST] == addr_lat));

  // R9: a write is reported once
  p_valid_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
  parameter int unsigned BUSY_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  generate
    if (BUSY_CYCLES == 0) begin : g_none
      logic unused_inputs;
      assign unused_inputs = clk ^ rst_n ^ start;
      assign busy = 1'b0;
    end else begin : g_count
      localparam int unsigned CW = $clog2(BUSY_CYCLES + 1);
      logic [CW-1:0] cnt, cnt_d;

      always_comb begin
        cnt_d = cnt;
        if (start) begin
          cnt_d = CW'(BUSY_CYCLES);
        end else if (cnt != '0) begin
          cnt_d = cnt - 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_d;
      end

      assign busy = (cnt != '0);

      // R8: a started operation is busy on the next cycle
      p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

      // R8: busy ends only from the last count
      p_busy_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(cnt) == CW'(1)));
    end
  endgenerate

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_seq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 17,
  parameter int unsigned SECT_LSB = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_valid,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [7:0]                 wr_data,
  input  logic                       busy,
  output logic                       fire,
  output logic                       prog_stb,
  output logic [ADDR_W-1:0]          prog_addr,
  output logic [7:0]                 prog_data,
  output logic                       erase_stb,
  output logic [ADDR_W-SECT_LSB-1:0] erase_sector
);

  localparam int unsigned SECT_W = ADDR_W - SECT_LSB;

  seq_state_e state, state_d;
  logic       fire_p, fire_e;
  logic       at_a, at_b, take;

  assign at_a = (wr_addr[CMD_AW-1:0] == CMD_ADDR_A);
  assign at_b = (wr_addr[CMD_AW-1:0] == CMD_ADDR_B);
  assign take = wr_valid & ~busy;

  always_comb begin
    state_d = state;
    fire_p  = 1'b0;
    fire_e  = 1'b0;
    if (take) begin
      if (state != ST_PROG && wr_data == OP_RESET) begin
        state_d = ST_IDLE;
      end else begin
        unique case (state)
          ST_IDLE: state_d = (at_a && wr_data == KEY_FIRST)  ? ST_UNL1 : ST_IDLE;
          ST_UNL1: state_d = (at_b && wr_data == KEY_SECOND) ? ST_UNL2 : ST_IDLE;
          ST_UNL2: begin
            if (at_a && wr_data == OP_PROGRAM)    state_d = ST_PROG;
            else if (at_a && wr_data == OP_ERASE) state_d = ST_ERA1;
            else                                  state_d = ST_IDLE;
          end
          ST_PROG: begin
            fire_p  = 1'b1;
            state_d = ST_IDLE;
          end
          ST_ERA1: state_d = (at_a && wr_data == KEY_FIRST)  ? ST_ERA2 : ST_IDLE;
          ST_ERA2: state_d = (at_b && wr_data == KEY_SECOND) ? ST_ERA3 : ST_IDLE;
          ST_ERA3: begin
            fire_e  = (wr_data == OP_SECTOR);
            state_d = ST_IDLE;
          end
          default: state_d = ST_IDLE;
        endcase
      end
    end
  end

  assign fire = fire_p | fire_e;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      prog_stb     <= 1'b0;
      erase_stb    <= 1'b0;
      prog_addr    <= '0;
      prog_data    <= '0;
      erase_sector <= '0;
    end else begin
      state     <= state_d;
      prog_stb  <= fire_p;
      erase_stb <= fire_e;
      if (fire_p) begin
        prog_addr <= wr_addr;
        prog_data <= wr_data;
      end
      if (fire_e) begin
        erase_sector <= wr_addr[ADDR_W-1:SECT_LSB];
      end
    end
  end

  // R9: strobes never overlap
  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_stb, erase_stb}));

  // R2: a program pulse follows a write taken in the data step
  p_prog_origin_r2: assert property (@(posedge clk) disable iff (!rst_n)
    prog_stb |-> ($past(state) == ST_PROG && $past(take)));

  // R3: an erase pulse follows the sector opcode in the last erase step
  p_erase_origin_r3: assert property (@(posedge clk) disable iff (!rst_n)
    erase_stb |-> ($past(state) == ST_ERA3 && $past(wr_data) == OP_SECTOR));

  // R6: the reset byte idles the machine outside the data step
  p_reset_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && state != ST_PROG && wr_data == OP_RESET)
      |=> (state == ST_IDLE && !prog_stb && !erase_stb));

  // R8: writes during busy do not move the sequence
  p_busy_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_valid) |=> $stable(state));

  // R9: strobes last one cycle
  p_prog_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    prog_stb |=> !prog_stb);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int unsigned ADDR_W      = 17,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD_CLKS   = 3,
  parameter int unsigned BUSY_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flash_ce_n,
  input  logic              flash_we_n,
  input  logic [ADDR_W-1:0] flash_addr,
  input  logic [7:0]        flash_data,
  output logic              prog_stb,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_data,
  output logic              erase_stb,
  output logic [ADDR_W-13:0] erase_sector,
  output logic              busy
);

  localparam int unsigned SECT_LSB = 12;

  // Asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_i = rst_pipe[1];

  logic              wr_valid;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;
  logic              fire;

  flash_bus_sync #(
    .ADDR_W      (ADDR_W),
    .SYNC_STAGES (SYNC_STAGES),
    .HOLD_CLKS   (HOLD_CLKS)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .ce_n     (flash_ce_n),
    .we_n     (flash_we_n),
    .addr     (flash_addr),
    .data     (flash_data),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  flash_cmd_fsm #(
    .ADDR_W   (ADDR_W),
    .SECT_LSB (SECT_LSB)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n_i),
    .wr_valid     (wr_valid),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .busy         (busy),
    .fire         (fire),
    .prog_stb     (prog_stb),
    .prog_addr    (prog_addr),
    .prog_data    (prog_data),
    .erase_stb    (erase_stb),
    .erase_sector (erase_sector)
  );

  flash_busy_timer #(
    .BUSY_CYCLES (BUSY_CYCLES)
  ) u_busy (
    .clk   (clk),
    .rst_n (rst_n_i),
    .start (fire),
    .busy  (busy)
  );

endmodule

// File: tb/flash_cmd_seq_tb.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb;

  localparam int unsigned AW   = 17;
  localparam int unsigned BUSY = 60;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    data = '0;
  logic          prog_stb, erase_stb, busy;
  logic [AW-1:0] prog_addr;
  logic [7:0]    prog_data;
  logic [AW-13:0] erase_sector;

  always #2 clk = ~clk;

  flash_cmd_seq #(
    .ADDR_W (AW), .SYNC_STAGES (2), .HOLD_CLKS (3), .BUSY_CYCLES (BUSY)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .flash_ce_n (ce_n), .flash_we_n (we_n),
    .flash_addr (addr), .flash_data (data),
    .prog_stb (prog_stb), .prog_addr (prog_addr), .prog_data (prog_data),
    .erase_stb (erase_stb), .erase_sector (erase_sector), .busy (busy)
  );

  int n_chk = 0, n_err = 0;
  int prog_cnt = 0, erase_cnt = 0;
  logic [AW-1:0]  seen_paddr = '0;
  logic [7:0]     seen_pdata = '0;
  logic [AW-13:0] seen_sect = '0;
  int busy_run = 0, busy_len = 0;

  // Output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (prog_stb)  begin prog_cnt++;  seen_paddr = prog_addr; seen_pdata = prog_data; end
    if (erase_stb) begin erase_cnt++; seen_sect = erase_sector; end
    if (busy) busy_run++;
    else if (busy_run != 0) begin busy_len = busy_run; busy_run = 0; end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; data = d;
    repeat (2) @(negedge clk); ce_n = 1'b0;
    @(negedge clk); we_n = 1'b0;
    repeat (4) @(negedge clk); we_n = 1'b1;
    repeat (3) @(negedge clk); ce_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // {kind, address, data}: kind 0 no pulse, 1 program, 2 erase
  localparam int NV = 45;
  localparam logic [26:0] VEC [NV] = '{
    {2'd0,17'h05555,8'hAA}, {2'd0,17'h02AAA,8'h55}, {2'd0,17'h05555,8'hA0},
    {2'd1,17'h12345,8'h3C},                                   // R2
    {2'd0,17'h15555,8'hAA}, {2'd0,17'h0AAAA,8'h55}, {2'd0,17'h05555,8'hA0},
    {2'd1,17'h00100,8'hF0},                                   // R4, R6 data step
    {2'd0,17'h05555,8'hAA}, {2'd0,17'h02AAA,8'h55}, {2'd0,17'h05555,8'h80},
    {2'd0,17'h05555,8'hAA}, {2'd0,17'h02AAA,8'h55},
    {2'd2,17'h17ABC,8'h30},                                   // R3
    {2'd0,17'h05555,8'hAA}, {2'd0,17'h02AAA,8'h55}, {2'd0,17'h05555,8'h80},
    {2'd0,17'h00000,8'hF0}, {2'd0,17'h03000,8'h30},           // R6 reset mid-erase
    {2'd0,17'h05555,8'hAA}, {2'd0,17'h02AAB,8'h55}, {2'd0,17'h05555,8'hA0},
    {2'd0,17'h04000,8'h77},                                   // R5 bad address
    {2'd0,17'h05555,8'hAA}, {2'd0,17'h02AAA,8'h55}, {2'd0,17'h05555,8'h80},
    {2'd0,17'h05555,8'hAA}, {2'd0,17'h02AAA,8'h55},
    {2'd0,17'h02000,8'h31}, {2'd0,17'h02000,8'h30},           // R5 bad data
    {2'd0,17'h05555,8'hAA}, {2'd0,17'h02AAA,8'h55}, {2'd0,17'h05555,8'h80},
    {2'd0,17'h05555,8'hAA}, {2'd0,17'h0AAAA,8'h55},
    {2'd2,17'h00FFF,8'h30},                                   // R3, R4 sector 0
    {2'd0,17'h05555,8'hAA}, {2'd0,17'h05555,8'hAA}, {2'd0,17'h02AAA,8'h55},
    {2'd0,17'h05555,8'hA0}, {2'd0,17'h01111,8'h99},           // R5 repeated key
    {2'd0,17'h05555,8'hAA}, {2'd0,17'h02AAA,8'h55}, {2'd0,17'h05555,8'hF0},
    {2'd0,17'h03333,8'h12}                                    // R6 reset after unlock
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int p0, e0;
    repeat (3) @(negedge clk);
    // R1: outputs during and after reset
    check(!prog_stb && !erase_stb && !busy, "R1", "outputs in reset",
          {prog_stb, erase_stb, busy}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!prog_stb && !erase_stb && !busy, "R1", "outputs after reset",
          {prog_stb, erase_stb, busy}, 0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [1:0]    kind;
      logic [AW-1:0] va;
      logic [7:0]    vd;
      {kind, va, vd} = VEC[i];
      p0 = prog_cnt; e0 = erase_cnt;
      bus_write(va, vd);
      repeat (2) @(negedge clk);
      case (kind)
        2'd1: begin
          check(prog_cnt == p0 + 1 && erase_cnt == e0, "R2", "program pulse count",
                prog_cnt - p0, 1);
          check(seen_paddr == va && seen_pdata == vd, "R2", "program address/data",
                {seen_paddr, seen_pdata}, {va, vd});
        end
        2'd2: begin
          check(erase_cnt == e0 + 1 && prog_cnt == p0, "R3", "erase pulse count",
                erase_cnt - e0, 1);
          check(seen_sect == va[AW-1:12], "R3", "erase sector",
                seen_sect, va[AW-1:12]);
        end
        default:
          check(prog_cnt == p0 && erase_cnt == e0, "R5", "no pulse expected",
                (prog_cnt - p0) + (erase_cnt - e0), 0);
      endcase
      wait_idle();
    end

    // R9: strobes were single-cycle; total pulse counts match the table
    check(prog_cnt == 2 && erase_cnt == 2, "R9", "pulse totals",
          prog_cnt * 16 + erase_cnt, 2 * 16 + 2);

    // R8: busy length and writes dropped while busy
    bus_write(17'h05555, 8'hAA); bus_write(17'h02AAA, 8'h55);
    bus_write(17'h05555, 8'hA0); bus_write(17'h05678, 8'h11);
    bus_write(17'h05555, 8'hAA); bus_write(17'h02AAA, 8'h55);
    bus_write(17'h05555, 8'hA0);
    check(busy == 1'b1, "R8", "still busy during dropped writes", busy, 1);
    wait_idle();
    check(busy_len == BUSY, "R8", "busy length", busy_len, BUSY);
    p0 = prog_cnt;
    bus_write(17'h06000, 8'h44);
    repeat (2) @(negedge clk);
    check(prog_cnt == p0, "R8", "sequence during busy was dropped", prog_cnt - p0, 0);
    wait_idle();

    // R7: chip-enable controlled write, address moves before it opens,
    // data moves after it closes
    bus_write(17'h05555, 8'hAA); bus_write(17'h02AAA, 8'h55);
    bus_write(17'h05555, 8'hA0);
    p0 = prog_cnt;
    @(negedge clk); addr = 17'h00111; data = 8'h5A; we_n = 1'b0;
    repeat (3) @(negedge clk); addr = 17'h01234;
    repeat (3) @(negedge clk); ce_n = 1'b0;
    repeat (4) @(negedge clk); ce_n = 1'b1;
    repeat (2) @(negedge clk); data = 8'hC3;
    repeat (3) @(negedge clk); we_n = 1'b1;
    repeat (4) @(negedge clk);
    check(prog_cnt == p0 + 1, "R7", "chip-enable write programmed", prog_cnt - p0, 1);
    check(seen_paddr == 17'h01234 && seen_pdata == 8'h5A, "R7", "captured address/data",
          {seen_paddr, seen_pdata}, {17'h01234, 8'h5A});
    wait_idle();

    // R1: reset in the middle of a program sequence
    bus_write(17'h05555, 8'hAA); bus_write(17'h02AAA, 8'h55);
    bus_write(17'h05555, 8'hA0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!prog_stb && !erase_stb && !busy, "R1", "outputs in mid-sequence reset",
          {prog_stb, erase_stb, busy}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    p0 = prog_cnt;
    bus_write(17'h01000, 8'h66);
    repeat (2) @(negedge clk);
    check(prog_cnt == p0, "R1", "no program after mid-sequence reset", prog_cnt - p0, 0);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule